// File: doc/BRIEF.md
# Xon/Xoff In-Band Flow Controller

This block gives a byte-oriented UART in-band flow control in both directions. It watches each received byte. When a byte, or a back-to-back pair of bytes, matches the programmed stop sequence, the block raises a pause flag for the local transmitter. When the bytes match the resume sequence, it clears the flag. Matched control bytes are removed from the data handed onward. When a first byte starts a pair but the next byte does not complete it, the first byte is released as ordinary data.

On the other side, the block compares the receive FIFO occupancy with two thresholds. When occupancy climbs above the upper threshold, it asks the transmitter to insert the stop character or characters. After that, once occupancy falls below the lower threshold, it asks for the resume character or characters. The insertion request uses a request/acknowledge handshake. The transmitter takes each requested character ahead of its queued data, at its next character boundary. Four character registers and a five-bit mode register are written through a small configuration port. Writes are accepted only while the line-control value equals an unlock code.

Top module: `swfc_top`

## Requirements
- R1: A configuration write takes effect on the next clock only when cfg_lcr equals UNLOCK (default 8'hBF); otherwise it changes nothing. Address map: 0 resume char 1, 1 resume char 2, 2 stop char 1, 3 stop char 2, 4 mode (bits 4:0). Addresses 5 to 7 are ignored. After reset all characters and the mode are zero.
- R2: Mode bits: bit0 enables receive matching, bit1 selects two-character receive matching, bit2 enables stop/resume insertion, bit3 selects two-character insertion, bit4 makes single-character operation use character 2 of each pair instead of character 1.
- R3: In single-character receive matching, a byte equal to the active stop character sets tx_pause on the next clock and is not forwarded. A byte equal to the active resume character clears tx_pause on the next clock and is not forwarded.
- R4: A received byte that is not a control byte appears on out_valid/out_data one clock after it is accepted, unchanged. With receive matching disabled, every byte is forwarded and tx_pause is held low.
- R5: In two-character receive matching, stop char 1 followed directly by stop char 2 sets tx_pause, and resume char 1 followed directly by resume char 2 clears it. Neither byte of a completed pair is forwarded.
- R6: In two-character receive matching, when a pending first byte is followed by a byte that does not complete the pair, the first byte is forwarded one clock after the second byte arrives. The second byte is then forwarded one clock later, unless it is itself a first character, in which case it becomes the new pending byte. Received bytes must be at least two clocks apart.
- R7: With insertion enabled and no stop outstanding, fifo_level strictly greater than trig_hi raises ins_req with the stop character on the next clock. The stop sequence is sent only once until a resume sequence has completed; a level equal to trig_hi requests nothing.
- R8: A resume request, with the resume character, is raised only after a stop sequence has been sent, and only when fifo_level is strictly below trig_lo.
- R9: ins_req and ins_char stay unchanged until ins_ack is seen with ins_req high. In two-character insertion, the second character is requested on the clock after the first is acknowledged.
- R10: After reset, out_valid, tx_pause and ins_req are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register address |
| cfg_wdata | input | DW | Configuration write data |
| cfg_lcr | input | 8 | Current line-control value; writes need UNLOCK |
| rx_valid | input | 1 | A received byte is present |
| rx_data | input | DW | Received byte |
| out_valid | output | 1 | Forwarded data byte valid |
| out_data | output | DW | Forwarded data byte |
| tx_pause | output | 1 | Transmitter must stop at the next character boundary |
| fifo_level | input | LW | Receive FIFO occupancy |
| trig_hi | input | LW | Level above which a stop sequence is requested |
| trig_lo | input | LW | Level below which a resume sequence is requested |
| ins_req | output | 1 | Request to insert a flow-control character |
| ins_char | output | DW | Character to insert |
| ins_ack | input | 1 | Transmitter has taken ins_char |

## Verification
Every result passes through exactly one register. Forwarded bytes, pause changes and new insertion requests therefore appear one clock after the input that causes them. The second byte of a mismatched pair comes out one clock later than that. The bench drives inputs on the falling edge and samples on the following falling edge, which is half a clock after the edge that registers the result. The spilled byte of a broken pair is sampled one further falling edge later. Acknowledge pulses last one clock, and the bench checks the state after that clock, so a repeat or missing request shows up at a known edge.

// File: rtl/swfc_pkg.sv
package swfc_pkg;
    // packed MSB first: alt_set is bit 4, rx_en is bit 0
    typedef struct packed {
        logic alt_set;
        logic tx_dual;
        logic tx_en;
        logic rx_dual;
        logic rx_en;
    } mode_t;

    typedef enum logic [1:0] {M_IDLE, M_OFF, M_ON} match_e;

    typedef enum logic [2:0] {S_IDLE, S_OFF1, S_OFF2, S_ON1, S_ON2} send_e;
endpackage

// File: rtl/swfc_cfg.sv
module swfc_cfg
    import swfc_pkg::*;
#(
    parameter int DW = 8,
    parameter logic [7:0] UNLOCK = 8'hBF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [2:0]    addr,
    input  logic [DW-1:0] wdata,
    input  logic [7:0]    lcr,
    output logic [DW-1:0] xon1,
    output logic [DW-1:0] xon2,
    output logic [DW-1:0] xoff1,
    output logic [DW-1:0] xoff2,
    output mode_t         mode
);
    typedef struct packed {
        logic [DW-1:0] xon1;
        logic [DW-1:0] xon2;
        logic [DW-1:0] xoff1;
        logic [DW-1:0] xoff2;
        mode_t         mode;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic unused_wdata_hi;
    assign unused_wdata_hi = ^wdata[DW-1:5];

    always_comb begin
        cfg_d = cfg_q;
        if (we && lcr == UNLOCK) begin
            case (addr)
                3'd0: cfg_d.xon1  = wdata;
                3'd1: cfg_d.xon2  = wdata;
                3'd2: cfg_d.xoff1 = wdata;
                3'd3: cfg_d.xoff2 = wdata;
                3'd4: cfg_d.mode  = mode_t'(wdata[4:0]);
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign xon1  = cfg_q.xon1;
    assign xon2  = cfg_q.xon2;
    assign xoff1 = cfg_q.xoff1;
    assign xoff2 = cfg_q.xoff2;
    assign mode  = cfg_q.mode;
endmodule

// File: rtl/swfc_rxmatch.sv
module swfc_rxmatch
    import swfc_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  mode_t         mode,
    input  logic [DW-1:0] xon1,
    input  logic [DW-1:0] xon2,
    input  logic [DW-1:0] xoff1,
    input  logic [DW-1:0] xoff2,
    input  logic          in_v,
    input  logic [DW-1:0] in_d,
    output logic          out_v,
    output logic [DW-1:0] out_d,
    output logic          pause
);
    typedef struct packed {
        match_e        st;
        logic [DW-1:0] held;
        logic          spill_v;
        logic [DW-1:0] spill_d;
        logic          ov;
        logic [DW-1:0] od;
        logic          pause;
    } rx_t;

    rx_t s_d, s_q;
    logic [DW-1:0] on_c, off_c;
    logic hit2;

    assign on_c  = mode.alt_set ? xon2  : xon1;
    assign off_c = mode.alt_set ? xoff2 : xoff1;

    always_comb begin
        s_d    = s_q;
        s_d.ov = 1'b0;
        hit2   = (s_q.st == M_OFF && in_d == xoff2) || (s_q.st == M_ON && in_d == xon2);
        if (!mode.rx_en) begin
            s_d.st      = M_IDLE;
            s_d.pause   = 1'b0;
            s_d.spill_v = 1'b0;
            if (in_v) begin
                s_d.ov = 1'b1;
                s_d.od = in_d;
            end
        end else begin
            if (s_q.spill_v) begin
                s_d.ov      = 1'b1;
                s_d.od      = s_q.spill_d;
                s_d.spill_v = 1'b0;
            end
            if (in_v) begin
                if (!mode.rx_dual) begin
                    s_d.st = M_IDLE;
                    if (in_d == off_c)     s_d.pause = 1'b1;
                    else if (in_d == on_c) s_d.pause = 1'b0;
                    else begin
                        s_d.ov = 1'b1;
                        s_d.od = in_d;
                    end
                end else if (hit2) begin
                    s_d.pause = (s_q.st == M_OFF);
                    s_d.st    = M_IDLE;
                end else begin
                    if (s_q.st != M_IDLE) begin
                        s_d.ov = 1'b1;
                        s_d.od = s_q.held;
                    end
                    if (in_d == xoff1) begin
                        s_d.st   = M_OFF;
                        s_d.held = in_d;
                    end else if (in_d == xon1) begin
                        s_d.st   = M_ON;
                        s_d.held = in_d;
                    end else begin
                        s_d.st = M_IDLE;
                        if (s_q.st != M_IDLE) begin
                            s_d.spill_v = 1'b1;
                            s_d.spill_d = in_d;
                        end else begin
                            s_d.ov = 1'b1;
                            s_d.od = in_d;
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: M_IDLE, default: '0};
        else        s_q <= s_d;
    end

    assign out_v = s_q.ov;
    assign out_d = s_q.od;
    assign pause = s_q.pause;
endmodule

// File: rtl/swfc_txins.sv
module swfc_txins
    import swfc_pkg::*;
#(
    parameter int DW = 8,
    parameter int LW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  mode_t         mode,
    input  logic [DW-1:0] xon1,
    input  logic [DW-1:0] xon2,
    input  logic [DW-1:0] xoff1,
    input  logic [DW-1:0] xoff2,
    input  logic [LW-1:0] level,
    input  logic [LW-1:0] trig_hi,
    input  logic [LW-1:0] trig_lo,
    input  logic          ack,
    output logic          req,
    output logic [DW-1:0] chr
);
    typedef struct packed {
        send_e st;
        logic  xoff_sent;
    } tx_t;

    tx_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (!mode.tx_en) begin
            t_d.st        = S_IDLE;
            t_d.xoff_sent = 1'b0;
        end else begin
            case (t_q.st)
                S_IDLE: begin
                    if (!t_q.xoff_sent && level > trig_hi) begin
                        t_d.st        = S_OFF1;
                        t_d.xoff_sent = 1'b1;
                    end else if (t_q.xoff_sent && level < trig_lo) begin
                        t_d.st = S_ON1;
                    end
                end
                S_OFF1: if (ack) t_d.st = mode.tx_dual ? S_OFF2 : S_IDLE;
                S_OFF2: if (ack) t_d.st = S_IDLE;
                S_ON1: begin
                    if (ack) begin
                        t_d.st = mode.tx_dual ? S_ON2 : S_IDLE;
                        if (!mode.tx_dual) t_d.xoff_sent = 1'b0;
                    end
                end
                S_ON2: begin
                    if (ack) begin
                        t_d.st        = S_IDLE;
                        t_d.xoff_sent = 1'b0;
                    end
                end
                default: t_d.st = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '{st: S_IDLE, xoff_sent: 1'b0};
        else        t_q <= t_d;
    end

    assign req = (t_q.st != S_IDLE);

    always_comb begin
        case (t_q.st)
            S_OFF1:  chr = (mode.tx_dual || !mode.alt_set) ? xoff1 : xoff2;
            S_OFF2:  chr = xoff2;
            S_ON1:   chr = (mode.tx_dual || !mode.alt_set) ? xon1 : xon2;
            S_ON2:   chr = xon2;
            default: chr = '0;
        endcase
    end
endmodule

// File: rtl/swfc_top.sv
module swfc_top
    import swfc_pkg::*;
#(
    parameter int DW = 8,
    parameter int LW = 6,
    parameter logic [7:0] UNLOCK = 8'hBF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [2:0]    cfg_addr,
    input  logic [DW-1:0] cfg_wdata,
    input  logic [7:0]    cfg_lcr,
    input  logic          rx_valid,
    input  logic [DW-1:0] rx_data,
    output logic          out_valid,
    output logic [DW-1:0] out_data,
    output logic          tx_pause,
    input  logic [LW-1:0] fifo_level,
    input  logic [LW-1:0] trig_hi,
    input  logic [LW-1:0] trig_lo,
    output logic          ins_req,
    output logic [DW-1:0] ins_char,
    input  logic          ins_ack
);
    logic [DW-1:0] xon1_w, xon2_w, xoff1_w, xoff2_w;
    mode_t         mode_w;

    swfc_cfg #(.DW(DW), .UNLOCK(UNLOCK)) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
        .wdata(cfg_wdata), .lcr(cfg_lcr),
        .xon1(xon1_w), .xon2(xon2_w), .xoff1(xoff1_w), .xoff2(xoff2_w),
        .mode(mode_w)
    );

    swfc_rxmatch #(.DW(DW)) u_rx (
        .clk(clk), .rst_n(rst_n), .mode(mode_w),
        .xon1(xon1_w), .xon2(xon2_w), .xoff1(xoff1_w), .xoff2(xoff2_w),
        .in_v(rx_valid), .in_d(rx_data),
        .out_v(out_valid), .out_d(out_data), .pause(tx_pause)
    );

    swfc_txins #(.DW(DW), .LW(LW)) u_tx (
        .clk(clk), .rst_n(rst_n), .mode(mode_w),
        .xon1(xon1_w), .xon2(xon2_w), .xoff1(xoff1_w), .xoff2(xoff2_w),
        .level(fifo_level), .trig_hi(trig_hi), .trig_lo(trig_lo),
        .ack(ins_ack), .req(ins_req), .chr(ins_char)
    );
endmodule

// File: rtl/swfc_checker.sv
module swfc_checker
    import swfc_pkg::*;
#(
    parameter int DW = 8,
    parameter logic [7:0] UNLOCK = 8'hBF
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_we,
    input logic [7:0]    cfg_lcr,
    input logic          rx_valid,
    input logic [DW-1:0] rx_data,
    input logic          out_valid,
    input logic [DW-1:0] out_data,
    input logic          tx_pause,
    input logic          ins_req,
    input logic [DW-1:0] ins_char,
    input logic          ins_ack,
    input logic [DW-1:0] xon1_w,
    input logic [DW-1:0] xon2_w,
    input logic [DW-1:0] xoff1_w,
    input logic [DW-1:0] xoff2_w,
    input mode_t         mode_w
);
    // R1: a locked write leaves every configuration register unchanged
    p_cfg_lock_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_lcr != UNLOCK) |=> ($stable(xon1_w) && $stable(xon2_w) &&
        $stable(xoff1_w) && $stable(xoff2_w) && $stable(mode_w)));

    // R3: single-character stop byte sets the pause flag
    p_pause_on_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !cfg_we && mode_w.rx_en && !mode_w.rx_dual &&
         rx_data == (mode_w.alt_set ? xoff2_w : xoff1_w)) |=> tx_pause);

    // R3: with stable single-character settings, a stop byte never leaves as data
    p_stop_not_forwarded_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(mode_w.rx_en && !mode_w.rx_dual) && $stable(mode_w) &&
         $stable(xoff1_w) && $stable(xoff2_w))
        |-> out_data != (mode_w.alt_set ? xoff2_w : xoff1_w));

    // R4: matching disabled keeps the pause flag low
    p_no_pause_disabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_w.rx_en && !cfg_we) |=> !tx_pause);

    // R9: an unacknowledged request holds its character
    p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_req && !ins_ack && !cfg_we) |=> (ins_req && $stable(ins_char)));
endmodule

bind swfc_top swfc_checker #(.DW(DW), .UNLOCK(UNLOCK)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_lcr(cfg_lcr),
    .rx_valid(rx_valid), .rx_data(rx_data),
    .out_valid(out_valid), .out_data(out_data), .tx_pause(tx_pause),
    .ins_req(ins_req), .ins_char(ins_char), .ins_ack(ins_ack),
    .xon1_w(xon1_w), .xon2_w(xon2_w), .xoff1_w(xoff1_w), .xoff2_w(xoff2_w),
    .mode_w(mode_w)
);

// File: tb/sim_swfc_top.sv
module sim_swfc_top;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 8;
    localparam int LW = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [2:0] cfg_addr = '0;
    logic [DW-1:0] cfg_wdata = '0;
    logic [7:0] cfg_lcr = '0;
    logic rx_valid = 1'b0;
    logic [DW-1:0] rx_data = '0;
    logic out_valid;
    logic [DW-1:0] out_data;
    logic tx_pause;
    logic [LW-1:0] fifo_level = '0;
    logic [LW-1:0] trig_hi = 6'd20;
    logic [LW-1:0] trig_lo = 6'd8;
    logic ins_req;
    logic [DW-1:0] ins_char;
    logic ins_ack = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    swfc_top u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_lcr(cfg_lcr), .rx_valid(rx_valid),
        .rx_data(rx_data), .out_valid(out_valid), .out_data(out_data),
        .tx_pause(tx_pause), .fifo_level(fifo_level), .trig_hi(trig_hi),
        .trig_lo(trig_lo), .ins_req(ins_req), .ins_char(ins_char),
        .ins_ack(ins_ack)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d, input logic [7:0] l);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d; cfg_lcr = l;
        @(negedge clk);
        cfg_we = 1'b0; cfg_lcr = 8'h03;
    endtask

    // one byte in; first sample one clock later, second sample one more clock later
    task automatic rx_byte(input logic [7:0] b, output logic v1, output logic [7:0] d1,
                           output logic p1, output logic v2, output logic [7:0] d2);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = b;
        @(negedge clk);
        rx_valid = 1'b0;
        v1 = out_valid; d1 = out_data; p1 = tx_pause;
        @(negedge clk);
        v2 = out_valid; d2 = out_data;
    endtask

    task automatic ack_pulse;
        @(negedge clk);
        ins_ack = 1'b1;
        @(negedge clk);
        ins_ack = 1'b0;
    endtask

    task automatic t_reset;
        chk("R10 out_valid", int'(out_valid), 0);
        chk("R10 tx_pause", int'(tx_pause), 0);
        chk("R10 ins_req", int'(ins_req), 0);
    endtask

    task automatic t_lock;
        logic v1, p1, v2;
        logic [7:0] d1, d2;
        wr(3'd0, 8'h11, 8'hBF);
        wr(3'd1, 8'h12, 8'hBF);
        wr(3'd2, 8'h13, 8'hBF);
        wr(3'd3, 8'h14, 8'hBF);
        wr(3'd4, 8'h01, 8'hBF);
        wr(3'd2, 8'h55, 8'h03);
        rx_byte(8'h13, v1, d1, p1, v2, d2);
        chk("R1 stop kept, not forwarded", int'(v1), 0);
        chk("R3 stop sets pause", int'(p1), 1);
        rx_byte(8'h55, v1, d1, p1, v2, d2);
        chk("R1 locked value forwarded valid", int'(v1), 1);
        chk("R1 locked value forwarded data", int'(d1), 8'h55);
    endtask

    task automatic t_single;
        logic v1, p1, v2;
        logic [7:0] d1, d2;
        rx_byte(8'h11, v1, d1, p1, v2, d2);
        chk("R3 resume dropped", int'(v1), 0);
        chk("R3 resume clears pause", int'(p1), 0);
        rx_byte(8'h41, v1, d1, p1, v2, d2);
        chk("R4 data forwarded valid", int'(v1), 1);
        chk("R4 data forwarded value", int'(d1), 8'h41);
        chk("R4 no repeat", int'(v2), 0);
        wr(3'd4, 8'h11, 8'hBF);
        rx_byte(8'h14, v1, d1, p1, v2, d2);
        chk("R2 alt stop sets pause", int'(p1), 1);
        chk("R2 alt stop dropped", int'(v1), 0);
        rx_byte(8'h13, v1, d1, p1, v2, d2);
        chk("R2 set-1 stop is data in alt", int'(d1), 8'h13);
        chk("R2 set-1 stop valid in alt", int'(v1), 1);
        rx_byte(8'h12, v1, d1, p1, v2, d2);
        chk("R2 alt resume clears pause", int'(p1), 0);
    endtask

    task automatic t_disabled;
        logic v1, p1, v2;
        logic [7:0] d1, d2;
        wr(3'd4, 8'h00, 8'hBF);
        rx_byte(8'h13, v1, d1, p1, v2, d2);
        chk("R4 disabled forwards stop byte", int'(v1), 1);
        chk("R4 disabled forwards value", int'(d1), 8'h13);
        chk("R4 disabled no pause", int'(p1), 0);
    endtask

    task automatic t_dual;
        logic v1, p1, v2;
        logic [7:0] d1, d2;
        wr(3'd4, 8'h03, 8'hBF);
        rx_byte(8'h13, v1, d1, p1, v2, d2);
        chk("R5 first stop held", int'(v1 | v2), 0);
        chk("R5 first stop no pause", int'(p1), 0);
        rx_byte(8'h14, v1, d1, p1, v2, d2);
        chk("R5 pair sets pause", int'(p1), 1);
        chk("R5 pair dropped", int'(v1 | v2), 0);
        rx_byte(8'h11, v1, d1, p1, v2, d2);
        rx_byte(8'h12, v1, d1, p1, v2, d2);
        chk("R5 resume pair clears pause", int'(p1), 0);
        chk("R5 resume pair dropped", int'(v1 | v2), 0);
        rx_byte(8'h13, v1, d1, p1, v2, d2);
        rx_byte(8'h41, v1, d1, p1, v2, d2);
        chk("R6 held byte released valid", int'(v1), 1);
        chk("R6 held byte released value", int'(d1), 8'h13);
        chk("R6 second byte next clock valid", int'(v2), 1);
        chk("R6 second byte next clock value", int'(d2), 8'h41);
        rx_byte(8'h13, v1, d1, p1, v2, d2);
        rx_byte(8'h14, v1, d1, p1, v2, d2);
        chk("R5 pause set again", int'(p1), 1);
        rx_byte(8'h13, v1, d1, p1, v2, d2);
        rx_byte(8'h11, v1, d1, p1, v2, d2);
        chk("R6 released stop1 before restart", int'(d1), 8'h13);
        chk("R6 restart byte not spilled", int'(v2), 0);
        rx_byte(8'h12, v1, d1, p1, v2, d2);
        chk("R6 restarted resume pair clears pause", int'(p1), 0);
        chk("R6 restarted pair dropped", int'(v1), 0);
    endtask

    task automatic t_send;
        wr(3'd4, 8'h04, 8'hBF);
        @(negedge clk); fifo_level = 6'd5;
        @(negedge clk); @(negedge clk);
        chk("R8 no resume before stop", int'(ins_req), 0);
        fifo_level = 6'd20;
        @(negedge clk); @(negedge clk);
        chk("R7 level equal to trig_hi idle", int'(ins_req), 0);
        fifo_level = 6'd21;
        @(negedge clk);
        chk("R7 stop requested", int'(ins_req), 1);
        chk("R7 stop char", int'(ins_char), 8'h13);
        repeat (3) @(negedge clk);
        chk("R9 request held", int'(ins_req), 1);
        chk("R9 char held", int'(ins_char), 8'h13);
        ack_pulse();
        chk("R7 request ends on ack", int'(ins_req), 0);
        fifo_level = 6'd25;
        repeat (3) @(negedge clk);
        chk("R7 stop sent only once", int'(ins_req), 0);
        fifo_level = 6'd8;
        repeat (2) @(negedge clk);
        chk("R8 level equal to trig_lo idle", int'(ins_req), 0);
        fifo_level = 6'd7;
        @(negedge clk);
        chk("R8 resume requested", int'(ins_req), 1);
        chk("R8 resume char", int'(ins_char), 8'h11);
        ack_pulse();
        repeat (2) @(negedge clk);
        chk("R8 resume sent once", int'(ins_req), 0);
    endtask

    task automatic t_send_dual;
        wr(3'd4, 8'h0C, 8'hBF);
        @(negedge clk); fifo_level = 6'd30;
        @(negedge clk);
        chk("R9 dual stop char 1", int'(ins_char), 8'h13);
        ack_pulse();
        chk("R9 dual second request", int'(ins_req), 1);
        chk("R9 dual stop char 2", int'(ins_char), 8'h14);
        ack_pulse();
        chk("R9 dual stop done", int'(ins_req), 0);
        fifo_level = 6'd2;
        @(negedge clk);
        chk("R9 dual resume char 1", int'(ins_char), 8'h11);
        ack_pulse();
        chk("R9 dual resume char 2", int'(ins_char), 8'h12);
        ack_pulse();
        chk("R9 dual resume done", int'(ins_req), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_lock();
        t_single();
        t_disabled();
        t_dual();
        t_send();
        t_send_dual();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule